// File: doc/BRIEF.md
# DMA Channel Interrupt and Status Hub

This block sits beside the channel engines of a multi-channel DMA controller and gathers their single-cycle event pulses into four event classes. The classes are transfer done, source fault, destination fault and setup fault. Each class keeps one sticky pending bit per channel. Software sees each class twice. The raw view shows every pending bit and clears bits written with a one. The masked view shows only bits whose channel has its interrupt enable set. One interrupt line is asserted while any masked bit in any class is set.

The block also decodes a 12-bit register bus. The upper half of the map holds the shared registers: the eight class views, a busy bitmap sampled from the channels, and two configuration words for an external arbiter (group priority and arbitration mode). The lower half is split into 64-byte windows, one per channel. An access there is routed to that channel with a one-hot select and the offset within the window, and the channel's read word is returned. Read data is registered and appears the cycle after the read is presented.

Top module: `dma_irq_status`

## Requirements
- R1: A one on a channel's pulse input in a class sets that channel's pending bit in that class at the next clock edge. Raw views are read at 0x810 (done, class 0), 0x814 (source fault, class 1), 0x818 (destination fault, class 2) and 0x81C (setup fault, class 3), with channel n at bit n.
- R2: A write to a raw view clears every pending bit whose write-data bit is one and leaves the other bits unchanged. An all-ones write empties the class.
- R3: When a pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R4: The masked views at 0x800, 0x804, 0x808 and 0x80C (classes 0 to 3) read as the raw bits ANDed with the per-channel `irq_en` input.
- R5: `irq` is high exactly when at least one masked bit of any class is set.
- R6: Writes to the masked views and to the busy bitmap change no state.
- R7: A read of 0x820 returns `chan_busy`, with channel n at bit n.
- R8: 0x824 (group priority) and 0x828 (arbitration mode) are read/write words that drive `prio_cfg` and `arb_cfg`. They change only when written.
- R9: An address below 0x800 selects channel addr[10:6] when that index is below NUM_CH. `win_sel` is then one-hot on that channel, `win_off` carries addr[5:0], and a read returns that channel's word from `win_rdata`. An index of NUM_CH or more selects nothing and reads zero.
- R10: Bits at or above NUM_CH read as zero. Unmapped or misaligned (addr[1:0] not 0) addresses in the upper half read as zero.
- R11: After reset all pending bits and both configuration words are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ev_done | input | NUM_CH | Transfer-done pulses |
| ev_src_err | input | NUM_CH | Source-fault pulses |
| ev_dst_err | input | NUM_CH | Destination-fault pulses |
| ev_cfg_err | input | NUM_CH | Setup-fault pulses |
| irq_en | input | NUM_CH | Per-channel interrupt enable |
| chan_busy | input | NUM_CH | Per-channel running flag |
| win_sel | output | NUM_CH | One-hot channel window select |
| win_we | output | 1 | Window write flag |
| win_off | output | 6 | Offset within the channel window |
| win_wdata | output | 32 | Window write data |
| win_rdata | input | NUM_CH*32 | Window read words, channel n at bits n*32 upward |
| prio_cfg | output | 32 | Group priority word |
| arb_cfg | output | 32 | Arbitration mode word (0 = equal) |
| irq | output | 1 | Combined interrupt |

## Verification
An event pulse and a software clear can target the same pending bit in one cycle. The bench provokes this with a single cycle that drives a destination-fault pulse on one channel together with a clear of the raw view. The clear covers both that channel and a neighbour that was already pending. The check is that the pulsed bit survives and the neighbour is dropped. A behavioural model that applies the clear first and the event second is compared with `irq` and the configuration outputs on every clock.

// File: rtl/dmaist_pkg.sv
`timescale 1ns/1ps
package dmaist_pkg;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned N_CLS   = 4;
    localparam int unsigned CHIDX_W = 5;
    localparam int unsigned WIN_LG  = 6;

    localparam logic [ADDR_W-1:0] A_MASK0 = 12'h800;
    localparam logic [ADDR_W-1:0] A_RAW0  = 12'h810;
    localparam logic [ADDR_W-1:0] A_BUSY  = 12'h820;
    localparam logic [ADDR_W-1:0] A_PRIO  = 12'h824;
    localparam logic [ADDR_W-1:0] A_ARB   = 12'h828;

    typedef enum logic [2:0] {
        RG_NONE, RG_WIN, RG_MASK, RG_RAW, RG_BUSY, RG_PRIO, RG_ARB
    } region_e;

    typedef struct packed {
        region_e              rg;
        logic [1:0]           cls;
        logic [CHIDX_W-1:0]   ch;
    } dec_t;
endpackage

// File: rtl/dmaist_decode.sv
`timescale 1ns/1ps
module dmaist_decode
    import dmaist_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [CHIDX_W-1:0] chi;
    logic [ADDR_W-1:0]  word;
    logic               aligned;

    always_comb begin
        chi     = addr[WIN_LG+CHIDX_W-1:WIN_LG];
        word    = {addr[ADDR_W-1:2], 2'b00};
        aligned = (addr[1:0] == 2'b00);
        dec.ch  = chi;
        dec.cls = addr[3:2];
        dec.rg  = RG_NONE;
        if (!addr[ADDR_W-1]) begin
            if (32'(chi) < NUM_CH) dec.rg = RG_WIN;
        end else if (aligned) begin
            if (word >= A_MASK0 && word < A_RAW0)     dec.rg = RG_MASK;
            else if (word >= A_RAW0 && word < A_BUSY) dec.rg = RG_RAW;
            else if (word == A_BUSY)                  dec.rg = RG_BUSY;
            else if (word == A_PRIO)                  dec.rg = RG_PRIO;
            else if (word == A_ARB)                   dec.rg = RG_ARB;
        end
    end
endmodule

// File: rtl/dmaist_evt_class.sv
`timescale 1ns/1ps
module dmaist_evt_class #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt,
    input  logic [NUM_CH-1:0] clr,
    input  logic [NUM_CH-1:0] en,
    output logic [NUM_CH-1:0] raw_o,
    output logic [NUM_CH-1:0] masked_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] pend;
    } cls_st_t;

    cls_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, then the new event, so the event wins a tie
        st_d.pend = (st_q.pend & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o    = st_q.pend;
    assign masked_o = st_q.pend & en;
endmodule

// File: rtl/dma_irq_status.sv
`timescale 1ns/1ps
module dma_irq_status
    import dmaist_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_CH-1:0]        ev_done,
    input  logic [NUM_CH-1:0]        ev_src_err,
    input  logic [NUM_CH-1:0]        ev_dst_err,
    input  logic [NUM_CH-1:0]        ev_cfg_err,
    input  logic [NUM_CH-1:0]        irq_en,
    input  logic [NUM_CH-1:0]        chan_busy,
    output logic [NUM_CH-1:0]        win_sel,
    output logic                     win_we,
    output logic [WIN_LG-1:0]        win_off,
    output logic [DATA_W-1:0]        win_wdata,
    input  logic [NUM_CH*DATA_W-1:0] win_rdata,
    output logic [DATA_W-1:0]        prio_cfg,
    output logic [DATA_W-1:0]        arb_cfg,
    output logic                     irq
);
    typedef struct packed {
        logic [DATA_W-1:0] prio;
        logic [DATA_W-1:0] arb;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;
    dec_t    dec;
    logic    wr_en, rd_en;
    logic [DATA_W-1:0] rd_val;

    logic [N_CLS-1:0][NUM_CH-1:0] ev_all, clr_all, raw_all, msk_all;

    function automatic logic [DATA_W-1:0] zext(input logic [NUM_CH-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NUM_CH-1:0] = v;
        return r;
    endfunction

    dmaist_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign wr_en  = bus_sel & bus_we;
    assign rd_en  = bus_sel & ~bus_we;
    assign ev_all = {ev_cfg_err, ev_dst_err, ev_src_err, ev_done};

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        assign clr_all[c] = (wr_en && dec.rg == RG_RAW && dec.cls == 2'(c))
                            ? bus_wdata[NUM_CH-1:0] : '0;
        dmaist_evt_class #(.NUM_CH(NUM_CH)) u_cls (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (ev_all[c]),
            .clr      (clr_all[c]),
            .en       (irq_en),
            .raw_o    (raw_all[c]),
            .masked_o (msk_all[c])
        );
    end

    assign irq = |msk_all;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            win_sel[i] = bus_sel && (dec.rg == RG_WIN) && (dec.ch == CHIDX_W'(i));
        end
    end
    assign win_we    = bus_we;
    assign win_off   = bus_addr[WIN_LG-1:0];
    assign win_wdata = bus_wdata;

    always_comb begin
        rd_val = '0;
        unique case (dec.rg)
            RG_WIN: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (dec.ch == CHIDX_W'(i)) rd_val = win_rdata[i*DATA_W +: DATA_W];
                end
            end
            RG_MASK: rd_val = zext(msk_all[dec.cls]);
            RG_RAW:  rd_val = zext(raw_all[dec.cls]);
            RG_BUSY: rd_val = zext(chan_busy);
            RG_PRIO: rd_val = st_q.prio;
            RG_ARB:  rd_val = st_q.arb;
            default: rd_val = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && dec.rg == RG_PRIO) st_d.prio = bus_wdata;
        if (wr_en && dec.rg == RG_ARB)  st_d.arb  = bus_wdata;
        if (rd_en)                      st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prio_cfg  = st_q.prio;
    assign arb_cfg   = st_q.arb;
    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/dma_irq_status_chk.sv
`timescale 1ns/1ps
module dma_irq_status_chk #(
    parameter int unsigned NUM_CH = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [3:0][NUM_CH-1:0] ev_all,
    input logic [3:0][NUM_CH-1:0] clr_all,
    input logic [3:0][NUM_CH-1:0] raw_all,
    input logic                   irq,
    input logic [NUM_CH-1:0]      win_sel,
    input logic                   wr_en,
    input logic [31:0]            prio_cfg,
    input logic [31:0]            arb_cfg
);
    for (genvar c = 0; c < 4; c++) begin : g_c
        // R1
        evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_all[c] != '0) |=> ((raw_all[c] & $past(ev_all[c])) == $past(ev_all[c])));
        // R2
        clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((clr_all[c] & ~ev_all[c]) != '0) |=> ((raw_all[c] & $past(clr_all[c] & ~ev_all[c])) == '0));
        // R2
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_all[c] == '0 && clr_all[c] == '0) |=> $stable(raw_all[c]));
        // R3
        evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((clr_all[c] & ev_all[c]) != '0) |=> ((raw_all[c] & $past(clr_all[c] & ev_all[c])) == $past(clr_all[c] & ev_all[c])));
    end

    // R5
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_all != '0));

    // R9
    win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_sel));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(prio_cfg) && $stable(arb_cfg)));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (raw_all == '0 && prio_cfg == '0 && arb_cfg == '0));
endmodule

bind dma_irq_status dma_irq_status_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_all   (ev_all),
    .clr_all  (clr_all),
    .raw_all  (raw_all),
    .irq      (irq),
    .win_sel  (win_sel),
    .wr_en    (wr_en),
    .prio_cfg (prio_cfg),
    .arb_cfg  (arb_cfg)
);

// File: tb/test_dma_irq_status.sv
`timescale 1ns/1ps
module test_dma_irq_status;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] ev_done = '0, ev_src_err = '0, ev_dst_err = '0, ev_cfg_err = '0;
    logic [NCH-1:0] irq_en = '0, chan_busy = '0;
    logic [NCH-1:0] win_sel;
    logic win_we;
    logic [5:0] win_off;
    logic [31:0] win_wdata;
    logic [NCH*32-1:0] win_rdata;
    logic [31:0] prio_cfg, arb_cfg;
    logic irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    function automatic logic [31:0] chdat(input int i);
        return {8'hA0 + 8'(i), 24'h00BEEF};
    endfunction

    always_comb begin
        for (int i = 0; i < NCH; i++) win_rdata[i*32 +: 32] = chdat(i);
    end

    dma_irq_status #(.NUM_CH(NCH)) i_dma_irq_status (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_done(ev_done), .ev_src_err(ev_src_err), .ev_dst_err(ev_dst_err),
        .ev_cfg_err(ev_cfg_err), .irq_en(irq_en), .chan_busy(chan_busy),
        .win_sel(win_sel), .win_we(win_we), .win_off(win_off),
        .win_wdata(win_wdata), .win_rdata(win_rdata),
        .prio_cfg(prio_cfg), .arb_cfg(arb_cfg), .irq(irq)
    );

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference: pending words per class, config words
    logic [31:0] m_raw [4] = '{default: '0};
    logic [31:0] m_prio = '0, m_arb = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) m_raw[c] <= '0;
            m_prio <= '0;
            m_arb  <= '0;
        end else begin
            for (int c = 0; c < 4; c++) begin
                logic [31:0] clr, ev;
                clr = '0;
                if (bus_sel && bus_we && bus_addr == 12'(12'h810 + 4*c)) clr = bus_wdata;
                case (c)
                    0: ev = 32'(ev_done);
                    1: ev = 32'(ev_src_err);
                    2: ev = 32'(ev_dst_err);
                    default: ev = 32'(ev_cfg_err);
                endcase
                m_raw[c] <= ((m_raw[c] & ~clr) | ev) & 32'hFF;
            end
            if (bus_sel && bus_we && bus_addr == 12'h824) m_prio <= bus_wdata;
            if (bus_sel && bus_we && bus_addr == 12'h828) m_arb  <= bus_wdata;
        end
    end

    always @(posedge clk) begin
        #2;
        if (!done) begin
            logic m_irq;
            m_irq = |((m_raw[0] | m_raw[1] | m_raw[2] | m_raw[3]) & 32'(irq_en));
            chk32("R5 irq vs model", {31'b0, irq}, {31'b0, m_irq});
            chk32("R8 prio vs model", prio_cfg, m_prio);
            chk32("R8 arb vs model", arb_cfg, m_arb);
        end
    end

    logic [31:0] s_rdata, s_wd;
    logic [NCH-1:0] s_sel;
    logic s_we;
    logic [5:0] s_off;

    task automatic xfer(input logic we, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        s_rdata = bus_rdata; s_sel = win_sel; s_we = win_we; s_off = win_off; s_wd = win_wdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        xfer(1'b0, a, 32'h0);
        chk32(tag, s_rdata, exp);
    endtask

    task automatic pulse(input int c, input logic [NCH-1:0] m);
        @(negedge clk);
        case (c)
            0: ev_done = m;
            1: ev_src_err = m;
            2: ev_dst_err = m;
            default: ev_cfg_err = m;
        endcase
        @(negedge clk);
        ev_done = '0; ev_src_err = '0; ev_dst_err = '0; ev_cfg_err = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk32("R11 irq in reset", {31'b0, irq}, 32'h0);
        chk32("R11 prio in reset", prio_cfg, 32'h0);
        rst_n = 1'b1;
        rd(12'h810, 32'h0, "R11 done raw after reset");
        rd(12'h81C, 32'h0, "R11 setup raw after reset");

        // R1 / R4 / R5
        pulse(0, 8'h05);
        rd(12'h810, 32'h05, "R1 done raw");
        rd(12'h800, 32'h00, "R4 masked with enables off");
        chk32("R5 irq low while masked", {31'b0, irq}, 32'h0);
        @(negedge clk); irq_en = 8'h04;
        rd(12'h800, 32'h04, "R4 masked with ch2 enabled");
        chk32("R5 irq high", {31'b0, irq}, 32'h1);
        pulse(1, 8'h80);
        pulse(2, 8'h10);
        pulse(3, 8'h01);
        rd(12'h814, 32'h80, "R1 source raw");
        rd(12'h818, 32'h10, "R1 dest raw");
        rd(12'h81C, 32'h01, "R1 setup raw");
        rd(12'h808, 32'h00, "R4 dest masked");
        @(negedge clk); irq_en = 8'hFF;
        rd(12'h80C, 32'h01, "R4 setup masked");

        // R2 clears
        xfer(1'b1, 12'h810, 32'h1);
        rd(12'h810, 32'h04, "R2 partial clear");
        xfer(1'b1, 12'h814, 32'hFFFF_FFFF);
        rd(12'h814, 32'h00, "R2 full clear");

        // R3 pulse and clear together
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h818; bus_wdata = 32'h30;
        ev_dst_err = 8'h20;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; ev_dst_err = '0;
        rd(12'h818, 32'h20, "R3 event beats clear");

        // R6 writes to read-only views
        xfer(1'b1, 12'h800, 32'h0);
        rd(12'h810, 32'h04, "R6 raw after masked write");
        rd(12'h800, 32'h04, "R6 masked after masked write");
        xfer(1'b1, 12'h820, 32'hFF);
        rd(12'h820, 32'h00, "R6 busy after write");

        // R7 / R10 busy bitmap
        @(negedge clk); chan_busy = 8'hA5;
        rd(12'h820, 32'hA5, "R7 busy bitmap R10 upper zero");

        // R8 config words
        xfer(1'b1, 12'h824, 32'h1234_5678);
        xfer(1'b1, 12'h828, 32'hCAFE_0001);
        rd(12'h824, 32'h1234_5678, "R8 prio readback");
        rd(12'h828, 32'hCAFE_0001, "R8 arb readback");
        chk32("R8 prio port", prio_cfg, 32'h1234_5678);
        xfer(1'b1, 12'h828, 32'h0);
        rd(12'h828, 32'h0, "R8 arb equal");

        // R9 channel windows
        xfer(1'b0, 12'h0C4, 32'h0);
        chk32("R9 read ch3 data", s_rdata, chdat(3));
        chk32("R9 read ch3 select", 32'(s_sel), 32'h08);
        chk32("R9 read ch3 offset", 32'(s_off), 32'h04);
        xfer(1'b1, 12'h1C8, 32'h55);
        chk32("R9 write ch7 select", 32'(s_sel), 32'h80);
        chk32("R9 write flag", {31'b0, s_we}, 32'h1);
        chk32("R9 write offset", 32'(s_off), 32'h08);
        chk32("R9 write data", s_wd, 32'h55);
        xfer(1'b0, 12'h200, 32'h0);
        chk32("R9 absent ch8 select", 32'(s_sel), 32'h0);
        chk32("R9 R10 absent ch8 data", s_rdata, 32'h0);

        // R10 holes
        rd(12'h82C, 32'h0, "R10 unmapped");
        rd(12'h812, 32'h0, "R10 misaligned");

        // R5 clearing drops irq only when all classes are empty
        xfer(1'b1, 12'h810, 32'hFFFF_FFFF);
        xfer(1'b1, 12'h818, 32'hFF);
        chk32("R5 irq from setup class", {31'b0, irq}, 32'h1);
        xfer(1'b1, 12'h81C, 32'hFFFF_FFFF);
        chk32("R5 irq cleared", {31'b0, irq}, 32'h0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule